// File: doc/BRIEF.md
# Scalar Saturating Shift-Right-Narrow Unit

This unit decodes one 32-bit instruction word and runs a scalar shift-right-by-immediate with narrowing and saturation. The operand is the lowest element of a 128-bit source vector. It is shifted right, clamped into a destination element that is half as wide, and returned in the lowest element of an otherwise zeroed 128-bit result. Three operations are recognised: signed input to signed result, signed input to unsigned result, and unsigned input to unsigned result.

A single 7-bit immediate carries both the element size and the shift count. Two reserved forms of that immediate are flagged as illegal. Words that match none of the three patterns are left alone, so that a neighbouring unit can claim them. The datapath is combinational and its results are captured in output registers on the next clock edge. A saturation flag reports every clamp, and the caller may OR it into a sticky status bit.

Top module: `ssrn_unit`

## Requirements
- R1: Bits [31:23]=010111110 with [15:10]=100101 select signed-to-signed. Bits [31:23]=011111110 with [15:10]=100001 select signed-to-unsigned. Bits [31:23]=011111110 with [15:10]=100101 select unsigned-to-unsigned. An accepted word raises wr_en_o, and rd_o then carries bits [4:0].
- R2: A word matching none of the three patterns gives wr_en_o=0, illegal_o=0, sat_o=0, data_o=0 and rd_o=0.
- R3: A matching word with immh (bits [22:19]) equal to 0000 gives illegal_o=1, wr_en_o=0 and data_o=0.
- R4: A matching word with immh bit 3 (instruction bit 22) set gives illegal_o=1, wr_en_o=0 and data_o=0.
- R5: The destination element width is 8, 16 or 32 bits for a highest set immh bit of 0, 1 or 2. The source element is twice that width. The shift count is the source width minus the unsigned value of {immh, immb} (bits [22:16]).
- R6: Both signed operations shift the source element arithmetically. The unsigned operation shifts it logically.
- R7: Signed-to-signed clamps the shifted value to the range -2^(e-1) .. 2^(e-1)-1, where e is the destination width.
- R8: Signed-to-unsigned clamps the signed shifted value to the range 0 .. 2^e-1.
- R9: Unsigned-to-unsigned clamps the shifted value to at most 2^e-1.
- R10: The result occupies the bits [e-1:0] of data_o and every other bit is zero. Source bits above the source element have no effect.
- R11: sat_o is 1 exactly when the clamp changed the value.
- R12: Outputs change only on a rising clock edge, one cycle after their inputs. An active-low asynchronous reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| instr_i | input | 32 | Instruction word |
| src_i | input | 128 | Source vector register value |
| data_o | output | 128 | Destination value, narrowed element in the low bits |
| rd_o | output | 5 | Destination register index |
| wr_en_o | output | 1 | Write enable for the destination |
| illegal_o | output | 1 | Reserved immediate on a recognised opcode |
| sat_o | output | 1 | Clamp altered the result |

## Verification
The assertions assume that instr_i and src_i are settled before each rising edge. They also assume that a cycle's outputs depend only on the previous cycle's inputs, so no handshake or hold requirement is involved. The bench changes its inputs only on falling edges and samples the outputs at the following falling edge, which keeps it within that assumption. The properties allow any 32-bit word, so the bench also drives words that match none of the patterns and words with reserved immediates.

// File: rtl/ssrn_pkg.sv
package ssrn_pkg;
  typedef enum logic [1:0] {
    OP_SS = 2'd0,
    OP_SU = 2'd1,
    OP_UU = 2'd2
  } ssrn_op_e;
endpackage

// File: rtl/ssrn_decode.sv
module ssrn_decode
  import ssrn_pkg::*;
(
  input  logic [31:0] instr_i,
  output ssrn_op_e    op_o,
  output logic        hit_o,
  output logic        bad_o,
  output logic [1:0]  esel_o,
  output logic [6:0]  shift_o
);
  localparam logic [8:0] PFX_S = 9'b010111110;
  localparam logic [8:0] PFX_U = 9'b011111110;
  localparam logic [5:0] OPC_N = 6'b100101;
  localparam logic [5:0] OPC_U = 6'b100001;

  logic [8:0] pfx;
  logic [5:0] opc;
  logic [3:0] immh;
  logic [6:0] imm7;
  logic [6:0] src_w;
  logic       m_ss, m_su, m_uu;

  assign pfx  = instr_i[31:23];
  assign opc  = instr_i[15:10];
  assign immh = instr_i[22:19];
  assign imm7 = instr_i[22:16];

  assign m_ss = (pfx == PFX_S) && (opc == OPC_N);
  assign m_su = (pfx == PFX_U) && (opc == OPC_U);
  assign m_uu = (pfx == PFX_U) && (opc == OPC_N);

  assign hit_o = m_ss | m_su | m_uu;
  assign bad_o = hit_o && ((immh == 4'b0000) || immh[3]);

  always_comb begin
    op_o = OP_SS;
    if (m_su) op_o = OP_SU;
    else if (m_uu) op_o = OP_UU;
  end

  always_comb begin
    if (immh[2])      esel_o = 2'd2;
    else if (immh[1]) esel_o = 2'd1;
    else              esel_o = 2'd0;
  end

  assign src_w   = 7'd16 << esel_o;
  assign shift_o = src_w - imm7;
endmodule

// File: rtl/ssrn_sat.sv
module ssrn_sat
  import ssrn_pkg::*;
#(
  parameter int XW = 64,
  localparam int NW = XW / 2
) (
  input  logic [XW-1:0] src_i,
  input  ssrn_op_e      op_i,
  input  logic [1:0]    esel_i,
  input  logic [6:0]    shift_i,
  output logic [NW-1:0] res_o,
  output logic          sat_o
);
  logic               sgn;
  logic signed [XW:0] ext, shf, hi_u, hi_s, lo_s, hi, lo, clmp;
  logic signed [XW:0] one_v;
  logic [6:0]         ew;

  assign sgn   = (op_i != OP_UU);
  assign ew    = 7'd8 << esel_i;
  assign one_v = {{XW{1'b0}}, 1'b1};

  // zero extension for the unsigned op makes >>> a logical shift
  always_comb begin
    case (esel_i)
      2'd0:    ext = {{(XW-15){sgn & src_i[15]}}, src_i[15:0]};
      2'd1:    ext = {{(XW-31){sgn & src_i[31]}}, src_i[31:0]};
      default: ext = {sgn & src_i[XW-1], src_i};
    endcase
  end

  assign shf  = ext >>> shift_i;
  assign hi_u = (one_v << ew) - one_v;
  assign hi_s = (one_v << (ew - 7'd1)) - one_v;
  assign lo_s = -(one_v << (ew - 7'd1));

  always_comb begin
    hi = (op_i == OP_SS) ? hi_s : hi_u;
    lo = (op_i == OP_SS) ? lo_s : '0;
    sat_o = 1'b0;
    clmp  = shf;
    if (shf > hi) begin
      clmp  = hi;
      sat_o = 1'b1;
    end else if (shf < lo) begin
      clmp  = lo;
      sat_o = 1'b1;
    end
  end

  assign res_o = clmp[NW-1:0] & hi_u[NW-1:0];
endmodule

// File: rtl/ssrn_unit.sv
module ssrn_unit
  import ssrn_pkg::*;
#(
  parameter int VLEN = 128,
  parameter int XW   = 64,
  localparam int NW  = XW / 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     instr_i,
  input  logic [VLEN-1:0] src_i,
  output logic [VLEN-1:0] data_o,
  output logic [4:0]      rd_o,
  output logic            wr_en_o,
  output logic            illegal_o,
  output logic            sat_o
);
  ssrn_op_e      op;
  logic          hit, bad, we, sat_c;
  logic [1:0]    esel;
  logic [6:0]    shift;
  logic [NW-1:0] res;
  logic          unused_bits;

  assign unused_bits = ^{src_i[VLEN-1:XW], instr_i[9:5]};

  ssrn_decode i_dec (
    .instr_i (instr_i),
    .op_o    (op),
    .hit_o   (hit),
    .bad_o   (bad),
    .esel_o  (esel),
    .shift_o (shift)
  );

  ssrn_sat #(.XW(XW)) i_sat (
    .src_i   (src_i[XW-1:0]),
    .op_i    (op),
    .esel_i  (esel),
    .shift_i (shift),
    .res_o   (res),
    .sat_o   (sat_c)
  );

  assign we = hit & ~bad;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o    <= '0;
      rd_o      <= '0;
      wr_en_o   <= 1'b0;
      illegal_o <= 1'b0;
      sat_o     <= 1'b0;
    end else begin
      wr_en_o   <= we;
      illegal_o <= bad;
      sat_o     <= we & sat_c;
      rd_o      <= we ? instr_i[4:0] : 5'd0;
      data_o    <= we ? {{(VLEN-NW){1'b0}}, res} : '0;
    end
  end
endmodule

// File: rtl/ssrn_chk.sv
module ssrn_chk #(
  parameter int VLEN = 128
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [31:0]     instr_i,
  input logic [VLEN-1:0] data_o,
  input logic            wr_en_o,
  input logic            illegal_o,
  input logic            sat_o
);
  // R3
  imm_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (instr_i[22:19] == 4'b0000) |=> !wr_en_o);

  // R4
  imm_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    instr_i[22] |=> !wr_en_o);

  // R3
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_o && illegal_o));

  // R11
  sat_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_o |-> wr_en_o);

  // R10
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> (data_o[VLEN-1:32] == '0));

  // R2
  idle_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_o |-> (data_o == '0));
endmodule

bind ssrn_unit ssrn_chk #(.VLEN(VLEN)) i_chk (.*);

// File: tb/test_ssrn_unit.sv
module test_ssrn_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  instr = '0;
  logic [127:0] src = '0;
  logic [127:0] data;
  logic [4:0]   rd;
  logic         we, ill, sat;
  int           total = 0;
  int           bad = 0;
  bit           done = 1'b0;

  always #10 clk = ~clk;

  ssrn_unit i_ssrn_unit (
    .clk_i(clk), .rst_ni(rst_n), .instr_i(instr), .src_i(src),
    .data_o(data), .rd_o(rd), .wr_en_o(we), .illegal_o(ill), .sat_o(sat)
  );

  typedef struct packed {
    logic [31:0]  ins;
    logic [127:0] src;
    logic [63:0]  dat;
    logic         we;
    logic         ill;
    logic         sat;
    logic [23:0]  tag;
  } vec_t;

  // op: 0 signed->signed, 1 signed->unsigned, 2 unsigned->unsigned
  function automatic logic [31:0] mk(int op, logic [3:0] h, logic [2:0] b, logic [4:0] d);
    logic [8:0] p;
    logic [5:0] o;
    p = (op == 0) ? 9'b010111110 : 9'b011111110;
    o = (op == 1) ? 6'b100001 : 6'b100101;
    return {p, h, b, o, 5'd3, d};
  endfunction

  localparam int NV = 21;
  localparam vec_t TBL [NV] = '{
    '{mk(0, 4'h1, 3'd0, 5'd1),  128'h1234,            64'h12,       1'b1, 1'b0, 1'b0, "R5 "},
    '{mk(0, 4'h1, 3'd7, 5'd2),  128'h7FFE,            64'h7F,       1'b1, 1'b0, 1'b1, "R7 "},
    '{mk(0, 4'h1, 3'd7, 5'd3),  128'h8000,            64'h80,       1'b1, 1'b0, 1'b1, "R7 "},
    '{mk(0, 4'h2, 3'd0, 5'd4),  128'hFFFF8000,        64'hFFFF,     1'b1, 1'b0, 1'b0, "R6 "},
    '{mk(1, 4'h1, 3'd0, 5'd5),  128'h80FF,            64'h0,        1'b1, 1'b0, 1'b1, "R6 "},
    '{mk(2, 4'h1, 3'd0, 5'd6),  128'h80FF,            64'h80,       1'b1, 1'b0, 1'b0, "R6 "},
    '{mk(1, 4'h4, 3'd0, 5'd7),  128'h1_2345_6789,     64'h1,        1'b1, 1'b0, 1'b0, "R8 "},
    '{mk(1, 4'h7, 3'd7, 5'd8),  128'h1_FFFF_FFFE,     64'hFFFFFFFF, 1'b1, 1'b0, 1'b0, "R8 "},
    '{mk(1, 4'h7, 3'd7, 5'd9),  128'h2_0000_0000,     64'hFFFFFFFF, 1'b1, 1'b0, 1'b1, "R11"},
    '{mk(1, 4'h3, 3'd7, 5'd10), 128'hFFFFFFFE,        64'h0,        1'b1, 1'b0, 1'b1, "R8 "},
    '{mk(2, 4'h4, 3'd0, 5'd11), 128'hFFFFFFFF_00000000, 64'hFFFFFFFF, 1'b1, 1'b0, 1'b0, "R9 "},
    '{mk(2, 4'h2, 3'd0, 5'd12), {64'hDEADBEEF_CAFEF00D, 32'hAAAAAAAA, 32'h12345678},
                                                      64'h1234,     1'b1, 1'b0, 1'b0, "R10"},
    '{mk(2, 4'h1, 3'd7, 5'd13), 128'hFFFF,            64'hFF,       1'b1, 1'b0, 1'b1, "R9 "},
    '{mk(0, 4'h7, 3'd7, 5'd14), 128'hFFFFFFFE,        64'h7FFFFFFF, 1'b1, 1'b0, 1'b0, "R7 "},
    '{mk(0, 4'h7, 3'd7, 5'd15), 128'hFFFFFFFF_00000000, 64'h80000000, 1'b1, 1'b0, 1'b0, "R7 "},
    '{mk(0, 4'h0, 3'd5, 5'd16), 128'h1234,            64'h0,        1'b0, 1'b1, 1'b0, "R3 "},
    '{mk(2, 4'h8, 3'd0, 5'd17), 128'hFFFF,            64'h0,        1'b0, 1'b1, 1'b0, "R4 "},
    '{mk(1, 4'hA, 3'd3, 5'd18), 128'h8000,            64'h0,        1'b0, 1'b1, 1'b0, "R4 "},
    '{{9'b010111110, 4'h1, 3'd0, 6'b100001, 5'd3, 5'd19}, 128'h7FFE, 64'h0, 1'b0, 1'b0, 1'b0, "R2 "},
    '{32'h0000_0000,            128'h7FFE,            64'h0,        1'b0, 1'b0, 1'b0, "R2 "},
    '{mk(2, 4'h2, 3'd5, 5'd31), 128'h0001_0000,       64'h20,       1'b1, 1'b0, 1'b0, "R1 "}
  };

  task automatic chk(input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic chk_all(input string t, input logic [127:0] d, input logic [4:0] r,
                         input logic w, input logic i, input logic s);
    chk({t, " data"}, data, d);
    chk({t, " rd"}, {123'd0, rd}, {123'd0, r});
    chk({t, " flags"}, {125'd0, we, ill, sat}, {125'd0, w, i, s});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R12: reset state
    repeat (2) @(negedge clk);
    chk_all("R12 reset", '0, 5'd0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R12 after release", '0, 5'd0, 1'b0, 1'b0, 1'b0);

    for (int k = 0; k < NV; k++) begin
      instr = TBL[k].ins;
      src   = TBL[k].src;
      @(negedge clk);
      chk_all(string'(TBL[k].tag), {64'd0, TBL[k].dat},
              TBL[k].we ? TBL[k].ins[4:0] : 5'd0, TBL[k].we, TBL[k].ill, TBL[k].sat);
    end

    // R12: outputs hold until the edge
    instr = TBL[1].ins;
    src   = TBL[1].src;
    @(negedge clk);
    instr = 32'h0;
    #2;
    chk_all("R12 hold", 128'h7F, 5'd2, 1'b1, 1'b0, 1'b1);
    @(negedge clk);
    chk_all("R12 next edge", '0, 5'd0, 1'b0, 1'b0, 1'b0);

    // R12: asynchronous reset mid-run
    instr = TBL[8].ins;
    src   = TBL[8].src;
    @(negedge clk);
    chk_all("R11 before reset", 128'hFFFFFFFF, 5'd9, 1'b1, 1'b0, 1'b1);
    rst_n = 1'b0;
    #2;
    chk_all("R12 async reset", '0, 5'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 resume", 128'hFFFFFFFF, 5'd9, 1'b1, 1'b0, 1'b1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule